// File: doc/BRIEF.md
# GPIO Port Controller

This block is a general-purpose I/O controller for a parameterised number of pins. The pin count must be a multiple of 32. Software reaches it through a small 32-bit register bus with one shared address port and separate read and write strobes. Through that bus it can:

- read the synchronised level of every pad;
- choose per pin whether it drives or listens;
- raise or lower output latches through write-one strobes, so one pin can change without a read-modify-write;
- pick a 2-bit alternate-function code per pin.

On the pin side the block takes a pad input vector and produces an output value vector and an output-enable vector. A pin's output driver is enabled only when the pin is configured as an output and its alternate-function code is zero (plain GPIO).

Register space is laid out feature first, then word. With `NREG = NUM_PINS/32`, feature `f` word `w` sits at byte address `f*NREG*4 + w*4`. The slots for edge detection (features 4, 5 and 6) belong to a separate block and read as zero here. The alternate-function block is the last feature and spans `2*NREG` words, because each word packs 16 pins.

Top module: `gpio_port_ctrl`

## Requirements
- R1: Feature indices are level=0, direction=1, set=2, clear=3, alternate-function=7. Feature `f` word `w` is at byte address `f*NREG*4 + w*4`. Address bits [1:0] are ignored. Pin `p` of the level, direction, set and clear registers is bit `p%32` of word `p/32`.
- R2: Reading the level register returns `pad_in` after a two-flop synchroniser. A change of `pad_in` is not visible to a read issued in the next cycle, but it is visible to the read after that. Writes to the level register have no effect.
- R3: The direction register is read/write. A bit value of 1 makes the pin an output and 0 makes it an input.
- R4: Writing a 1 to a bit of the set register drives that pin's output latch high. Zero bits leave the latch unchanged.
- R5: Writing a 1 to a bit of the clear register drives that pin's output latch low. Zero bits leave the latch unchanged.
- R6: The set and clear registers read back as zero.
- R7: Each pin has a read/write 2-bit alternate-function field. Pin `p` lives in alternate-function word `p/16` (byte address `7*NREG*4 + (p/16)*4`) at bit shift `(p%16)*2`.
- R8: `pad_oe[p]` is 1 exactly when the pin's direction bit is 1 and its alternate-function field is 0.
- R9: `pad_out` always shows the output latches, whatever the direction and alternate-function settings. Outputs change only through bus writes.
- R10: Reset (`rst_n` low, asynchronous) clears all direction bits, output latches and alternate-function fields.
- R11: Writes to unmapped addresses are ignored. Unmapped addresses are the edge-feature slots (features 4 to 6) and everything at or above `9*NREG*4`. Reads from unmapped addresses return zero.
- R12: Read data is registered. It appears in `bus_rdata` in the cycle after `bus_rd_en` and is zero in any cycle that follows a cycle without a read.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr_en | input | 1 | Write strobe for one cycle |
| bus_rd_en | input | 1 | Read strobe for one cycle |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| pad_in | input | NUM_PINS | Pad input levels (asynchronous) |
| pad_out | output | NUM_PINS | Output latch values |
| pad_oe | output | NUM_PINS | Output driver enables |

## Verification
On every cycle the bound checker confirms four things:

- after a write to the set or clear register, every addressed bit of `pad_out` has the requested value;
- the pad outputs and enables hold still in any cycle without a write;
- read data is zero after an idle cycle;
- reads of the set, clear and unmapped addresses return zero.

Some behaviours only the directed scenarios can show:

- the exact placement of words and alternate-function fields in the address map;
- the two-cycle latency of the synchroniser;
- the combined direction-and-function gating of the enables;
- the clearing effect of a reset applied mid-run.

// File: rtl/gpio_pkg.sv
package gpio_pkg;

  typedef enum logic [2:0] {
    FT_LEVEL = 3'd0,
    FT_DIR   = 3'd1,
    FT_SET   = 3'd2,
    FT_CLR   = 3'd3,
    FT_RISE  = 3'd4,
    FT_FALL  = 3'd5,
    FT_EDGE  = 3'd6,
    FT_ALT   = 3'd7
  } gpio_feat_e;

  typedef struct packed {
    logic       hit;
    gpio_feat_e feat;
    logic [15:0] sub;
  } gpio_dec_t;

  // Map a byte address onto feature / word-within-feature.
  function automatic gpio_dec_t gpio_decode(input logic [31:0] byte_addr,
                                            input int unsigned nreg);
    gpio_dec_t   d;
    int unsigned wi;
    wi    = int'(byte_addr >> 2);
    d.hit = 1'b0;
    d.feat = FT_LEVEL;
    d.sub  = '0;
    if (wi < 9 * nreg) begin
      if (wi >= 7 * nreg) begin
        d.feat = FT_ALT;
        d.sub  = 16'(wi - 7 * nreg);
      end else begin
        d.feat = gpio_feat_e'(3'(wi / nreg));
        d.sub  = 16'(wi % nreg);
      end
      d.hit = !(d.feat inside {FT_RISE, FT_FALL, FT_EDGE});
    end
    return d;
  endfunction

  // Plain-GPIO test on one packed 2-bit function field.
  function automatic logic gpio_fn_is_plain(input logic [1:0] fld);
    return fld == 2'b00;
  endfunction

endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int W      = 64,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) stg[i] <= '0;
    end else begin
      stg[0] <= d;
      for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/gpio_bank_regs.sv
module gpio_bank_regs import gpio_pkg::*; #(
  parameter int NUM_PINS = 64
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_en,
  input  gpio_dec_t             wr_dec,
  input  logic [31:0]           wr_data,
  output logic [NUM_PINS-1:0]   dir_q,
  output logic [NUM_PINS-1:0]   out_q,
  output logic [2*NUM_PINS-1:0] alt_q
);
  localparam int NREG      = NUM_PINS / 32;
  localparam int ALT_WORDS = 2 * NREG;

  logic wr_dir, wr_set, wr_clr, wr_alt;
  assign wr_dir = wr_en && wr_dec.hit && (wr_dec.feat == FT_DIR);
  assign wr_set = wr_en && wr_dec.hit && (wr_dec.feat == FT_SET);
  assign wr_clr = wr_en && wr_dec.hit && (wr_dec.feat == FT_CLR);
  assign wr_alt = wr_en && wr_dec.hit && (wr_dec.feat == FT_ALT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir_q <= '0;
      out_q <= '0;
    end else begin
      for (int w = 0; w < NREG; w++) begin
        if (wr_dec.sub == 16'(w)) begin
          if (wr_dir) dir_q[w*32 +: 32] <= wr_data;
          if (wr_set) out_q[w*32 +: 32] <= out_q[w*32 +: 32] | wr_data;
          if (wr_clr) out_q[w*32 +: 32] <= out_q[w*32 +: 32] & ~wr_data;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      alt_q <= '0;
    end else begin
      for (int a = 0; a < ALT_WORDS; a++) begin
        if (wr_alt && wr_dec.sub == 16'(a)) alt_q[a*32 +: 32] <= wr_data;
      end
    end
  end
endmodule

// File: rtl/gpio_read_mux.sv
module gpio_read_mux import gpio_pkg::*; #(
  parameter int NUM_PINS = 64
) (
  input  gpio_dec_t             rd_dec,
  input  logic [NUM_PINS-1:0]   level,
  input  logic [NUM_PINS-1:0]   dir_q,
  input  logic [2*NUM_PINS-1:0] alt_q,
  output logic [31:0]           rd_word
);
  localparam int NREG      = NUM_PINS / 32;
  localparam int ALT_WORDS = 2 * NREG;

  always_comb begin
    rd_word = '0;
    if (rd_dec.hit) begin
      unique case (rd_dec.feat)
        FT_LEVEL: for (int w = 0; w < NREG; w++)
                    if (rd_dec.sub == 16'(w)) rd_word = level[w*32 +: 32];
        FT_DIR:   for (int w = 0; w < NREG; w++)
                    if (rd_dec.sub == 16'(w)) rd_word = dir_q[w*32 +: 32];
        FT_ALT:   for (int a = 0; a < ALT_WORDS; a++)
                    if (rd_dec.sub == 16'(a)) rd_word = alt_q[a*32 +: 32];
        default:  rd_word = '0;
      endcase
    end
  end
endmodule

// File: rtl/gpio_port_ctrl.sv
module gpio_port_ctrl import gpio_pkg::*; #(
  parameter int NUM_PINS = 64,
  parameter int ADDR_W   = $clog2(NUM_PINS / 32 * 9 * 4)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                bus_wr_en,
  input  logic                bus_rd_en,
  input  logic [ADDR_W-1:0]   bus_addr,
  input  logic [31:0]         bus_wdata,
  output logic [31:0]         bus_rdata,
  input  logic [NUM_PINS-1:0] pad_in,
  output logic [NUM_PINS-1:0] pad_out,
  output logic [NUM_PINS-1:0] pad_oe
);
  localparam int NREG = NUM_PINS / 32;

  gpio_dec_t             bus_dec;
  logic [NUM_PINS-1:0]   level_sync;
  logic [NUM_PINS-1:0]   dir_q;
  logic [NUM_PINS-1:0]   out_q;
  logic [2*NUM_PINS-1:0] alt_q;
  logic [31:0]           rd_word;

  assign bus_dec = gpio_decode(32'(bus_addr), NREG);

  gpio_sync #(.W(NUM_PINS), .STAGES(2)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(pad_in), .q(level_sync)
  );

  gpio_bank_regs #(.NUM_PINS(NUM_PINS)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(bus_wr_en), .wr_dec(bus_dec),
    .wr_data(bus_wdata), .dir_q(dir_q), .out_q(out_q), .alt_q(alt_q)
  );

  gpio_read_mux #(.NUM_PINS(NUM_PINS)) u_rmux (
    .rd_dec(bus_dec), .level(level_sync), .dir_q(dir_q),
    .alt_q(alt_q), .rd_word(rd_word)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) bus_rdata <= '0;
    else        bus_rdata <= bus_rd_en ? rd_word : 32'h0;
  end

  for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
    assign pad_oe[p] = dir_q[p] & gpio_fn_is_plain(alt_q[2*p +: 2]);
  end

  assign pad_out = out_q;
endmodule

// File: rtl/gpio_port_ctrl_chk.sv
module gpio_port_ctrl_chk import gpio_pkg::*; #(
  parameter int NUM_PINS = 64,
  parameter int ADDR_W   = 7
) (
  input logic                clk,
  input logic                rst_n,
  input logic                bus_wr_en,
  input logic                bus_rd_en,
  input logic [ADDR_W-1:0]   bus_addr,
  input logic [31:0]         bus_wdata,
  input logic [31:0]         bus_rdata,
  input logic [NUM_PINS-1:0] pad_out,
  input logic [NUM_PINS-1:0] pad_oe
);
  localparam int NREG = NUM_PINS / 32;

  gpio_dec_t d;
  assign d = gpio_decode(32'(bus_addr), NREG);

  function automatic logic [NUM_PINS-1:0] place(input logic [31:0] v,
                                                input logic [15:0] sub);
    logic [NUM_PINS-1:0] m;
    m = '0;
    for (int w = 0; w < NREG; w++) if (sub == 16'(w)) m[w*32 +: 32] = v;
    return m;
  endfunction

  logic                set_pend, clr_pend;
  logic [NUM_PINS-1:0] set_mask, clr_mask;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      set_pend <= 1'b0;
      clr_pend <= 1'b0;
      set_mask <= '0;
      clr_mask <= '0;
    end else begin
      set_pend <= bus_wr_en && d.hit && d.feat == FT_SET;
      clr_pend <= bus_wr_en && d.hit && d.feat == FT_CLR;
      set_mask <= place(bus_wdata, d.sub);
      clr_mask <= place(bus_wdata, d.sub);
    end
  end

  // R4
  set_drives_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    set_pend |-> ((pad_out & set_mask) == set_mask));

  // R5
  clr_drives_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr_pend |-> ((pad_out & clr_mask) == '0));

  // R9
  out_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_wr_en |=> $stable(pad_out));

  // R3
  oe_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_wr_en |=> $stable(pad_oe));

  // R12
  rdata_idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_rd_en |=> bus_rdata == 32'h0);

  // R6
  strobe_reg_reads_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd_en && d.hit && (d.feat == FT_SET || d.feat == FT_CLR)) |=> bus_rdata == 32'h0);

  // R11
  unmapped_reads_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd_en && !d.hit) |=> bus_rdata == 32'h0);
endmodule

bind gpio_port_ctrl gpio_port_ctrl_chk #(.NUM_PINS(NUM_PINS), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_wr_en(bus_wr_en), .bus_rd_en(bus_rd_en),
  .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
  .pad_out(pad_out), .pad_oe(pad_oe)
);

// File: tb/sim_gpio_port_ctrl.sv
`timescale 1ns/1ps
module sim_gpio_port_ctrl;
  localparam int N  = 64;
  localparam int AW = 7;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          bus_wr_en = 1'b0;
  logic          bus_rd_en = 1'b0;
  logic [AW-1:0] bus_addr = '0;
  logic [31:0]   bus_wdata = '0;
  logic [31:0]   bus_rdata;
  logic [N-1:0]  pad_in = '0;
  logic [N-1:0]  pad_out;
  logic [N-1:0]  pad_oe;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  gpio_port_ctrl #(.NUM_PINS(N)) u0 (
    .clk(clk), .rst_n(rst_n), .bus_wr_en(bus_wr_en), .bus_rd_en(bus_rd_en),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe)
  );

  // Address map for 64 pins (two words per feature)
  function automatic logic [AW-1:0] adr(input int f, input int w);
    return AW'(f * 8 + w * 4);
  endfunction

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [31:0] v);
    @(negedge clk);
    bus_wr_en = 1'b1; bus_addr = a; bus_wdata = v;
    @(negedge clk);
    bus_wr_en = 1'b0;
  endtask

  task automatic rd(input logic [AW-1:0] a, output logic [31:0] v);
    @(negedge clk);
    bus_rd_en = 1'b1; bus_addr = a;
    @(negedge clk);
    bus_rd_en = 1'b0;
    v = bus_rdata;
  endtask

  task automatic t_reset;
    logic [31:0] v;
    check("R10 pad_out after reset", pad_out, '0);
    check("R10 pad_oe after reset", pad_oe, '0);
    rd(adr(1, 1), v); check("R10 dir word1 after reset", 64'(v), 0);
    rd(adr(7, 3), v); check("R10 alt word3 after reset", 64'(v), 0);
  endtask

  task automatic t_level;
    logic [31:0] v;
    @(negedge clk); pad_in = 64'hDEAD_BEEF_1234_5678;
    rd(adr(0, 0), v); check("R2 level not yet visible", 64'(v), 0);
    rd(adr(0, 0), v); check("R2 level word0", 64'(v), 64'h1234_5678);
    rd(adr(0, 1), v); check("R1 level word1", 64'(v), 64'hDEAD_BEEF);
    wr(adr(0, 0), 32'hFFFF_FFFF);
    rd(adr(0, 0), v); check("R2 level write ignored", 64'(v), 64'h1234_5678);
  endtask

  task automatic t_dir;
    logic [31:0] v;
    wr(adr(1, 1), 32'hA5A5_0F0F);
    rd(adr(1, 1), v); check("R3 dir word1 readback", 64'(v), 64'hA5A5_0F0F);
    check("R8 pad_oe follows dir", pad_oe, 64'hA5A5_0F0F_0000_0000);
    wr(7'(adr(1, 0) + 3), 32'h1234_5678);
    rd(adr(1, 0), v); check("R1 low address bits ignored", 64'(v), 64'h1234_5678);
    check("R8 pad_oe word0", pad_oe, 64'hA5A5_0F0F_1234_5678);
  endtask

  task automatic t_setclr;
    logic [31:0] v;
    wr(adr(2, 0), 32'h0000_00FF);
    check("R4 set word0", pad_out, 64'h0000_0000_0000_00FF);
    wr(adr(2, 0), 32'hF000_0000);
    check("R4 zero bits keep latch", pad_out, 64'h0000_0000_F000_00FF);
    wr(adr(2, 1), 32'h8000_0001);
    check("R4 set word1", pad_out, 64'h8000_0001_F000_00FF);
    wr(adr(3, 0), 32'h0000_000F);
    check("R5 clear word0", pad_out, 64'h8000_0001_F000_00F0);
    wr(adr(3, 1), 32'h0000_0001);
    check("R5 clear word1", pad_out, 64'h8000_0000_F000_00F0);
    rd(adr(2, 0), v); check("R6 set reads zero", 64'(v), 0);
    rd(adr(3, 1), v); check("R6 clear reads zero", 64'(v), 0);
  endtask

  task automatic t_alt;
    logic [31:0] v;
    logic [63:0] out_before;
    out_before = pad_out;
    wr(adr(1, 0), 32'hFFFF_FFFF);
    wr(adr(1, 1), 32'hFFFF_FFFF);
    check("R8 all outputs enabled", pad_oe, 64'hFFFF_FFFF_FFFF_FFFF);
    wr(adr(7, 0), 32'h0000_000C);  // pin 1  -> word 0, shift 2, code 3
    wr(adr(7, 1), 32'h0000_0004);  // pin 17 -> word 1, shift 2, code 1
    wr(adr(7, 3), 32'h0000_0002);  // pin 48 -> word 3, shift 0, code 2
    check("R7 R8 alt gates oe",
          pad_oe, ~((64'h1 << 1) | (64'h1 << 17) | (64'h1 << 48)));
    rd(adr(7, 1), v); check("R7 alt word1 readback", 64'(v), 64'h4);
    rd(adr(7, 3), v); check("R7 alt word3 readback", 64'(v), 64'h2);
    check("R9 pad_out independent of alt", pad_out, out_before);
    wr(adr(1, 1), 32'h0);
    check("R9 pad_out independent of dir", pad_out, out_before);
  endtask

  task automatic t_unmapped;
    logic [31:0] v;
    logic [63:0] o, e;
    o = pad_out; e = pad_oe;
    wr(adr(4, 0), 32'hFFFF_FFFF);
    wr(adr(6, 1), 32'hFFFF_FFFF);
    wr(7'h48, 32'hFFFF_FFFF);
    wr(7'h7C, 32'h0);
    check("R11 pad_out unchanged", pad_out, o);
    check("R11 pad_oe unchanged", pad_oe, e);
    rd(adr(1, 0), v); check("R11 dir intact", 64'(v), 64'hFFFF_FFFF);
    rd(adr(4, 0), v); check("R11 edge slot reads zero", 64'(v), 0);
    rd(7'h48, v);     check("R11 beyond map reads zero", 64'(v), 0);
  endtask

  task automatic t_rdidle;
    logic [31:0] v;
    rd(adr(1, 0), v); check("R12 read data present", 64'(v), 64'hFFFF_FFFF);
    @(negedge clk);
    check("R12 idle rdata zero", 64'(bus_rdata), 0);
  endtask

  task automatic t_midreset;
    logic [31:0] v;
    @(negedge clk); rst_n = 1'b0;
    #1;
    check("R10 async reset pad_out", pad_out, '0);
    check("R10 async reset pad_oe", pad_oe, '0);
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    rd(adr(7, 0), v); check("R10 alt cleared", 64'(v), 0);
    rd(adr(1, 0), v); check("R10 dir cleared", 64'(v), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_level();
    t_dir();
    t_setclr();
    t_alt();
    t_unmapped();
    t_rdidle();
    t_midreset();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule